// File: doc/BRIEF.md
# Monochrome LCD Panel Controller

This block refreshes a single-scan monochrome LCD panel from a frame buffer held in main memory. It fetches the image itself through a burst read port, so the processor never copies pixels. Each 32-bit word is unpacked at 1, 2 or 4 bits per pixel. The result goes to the panel four pixels at a time on a 4-bit data bus, together with a shift strobe, a line pulse and a frame marker.

Line length is set in 16-pixel steps from 16 to 1024 pixels. The line count is programmable, up to a 128-Kbyte image. At 2 and 4 bits per pixel the grey level of each pixel is turned into an on/off pattern that changes from frame to frame. A small prefetch FIFO holds fetched words between memory and the panel. If the FIFO runs dry, the panel gets blank pixels and the line timing keeps running.

Configuration is taken while the block is disabled and is held while it runs. To change pixel depth at run time, drop the enable, write the new setting and raise the enable again.

Top module: `lcd_mono_ctrl`

## Requirements
- R1: While reset or `en` is low, `lcd_shift`, `lcd_line`, `lcd_frame` and `underflow` are 0. No new fetch request is raised while `en` is low.
- R2: Each line is `4*(cfg_len+1)` consecutive cycles with `lcd_shift`=1, followed by exactly one cycle with `lcd_line`=1 and `lcd_shift`=0. The next line follows at once.
- R3: Pixels are packed least-significant first in each 32-bit word, so a word holds 32, 16 or 8 pixels. Every line starts on a fresh word, and unused pixels at the end of a line's last word are skipped. In a shift cycle, `lcd_d[j]` carries pixel `4*g+j` of the line, where g counts that line's shift cycles from 0.
- R4: With `cfg_bpp`=0 (1 bit per pixel), `lcd_d[j]` is the pixel bit itself.
- R5: With `cfg_bpp`=1 (2 bits) or `cfg_bpp`=2 (4 bits), a pixel is on when its level is greater than the low 2 bits (or all 4 bits) of a frame counter. That counter is 0 for the first frame after enable, advances after the last line pulse of each frame and wraps at 16.
- R6: `lcd_frame` is 1 through all shift cycles and the line pulse of the first line of each frame, and 0 on all other lines.
- R7: Words are fetched in order from `cfg_base + line*W + k`. W is `(cfg_len+2)/2`, `cfg_len+1` or `2*(cfg_len+1)` words at 1, 2 or 4 bits per pixel. After the last of `cfg_lines+1` lines the address wraps to `cfg_base`. A request carries `min(4, words left in frame)` words.
- R8: A request is raised only when FIFO words plus words requested but not yet returned leave room for a full burst. Words still queued never exceed the FIFO depth, and `mem_req` with its address and length holds until `mem_ack`.
- R9: If a word is due while the FIFO is empty, the pixels that word covers are driven as 0. The late word is dropped when it arrives, and the line timing is unchanged. `underflow` goes to 1 and stays 1 until `en` falls.
- R10: Configuration is captured while `en` is low, so a new depth, length or base takes effect at the next enable. Words still in flight at disable are discarded.
- R11: After enable, shifting does not start until at least one burst of words has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low flushes and allows configuration |
| cfg_len | input | 6 | Line length minus one, in 16-pixel units |
| cfg_bpp | input | 2 | 0: 1 bpp, 1: 2 bpp, 2 or 3: 4 bpp |
| cfg_lines | input | LW | Lines per frame minus one |
| cfg_base | input | AW | Frame buffer base, word address |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | AW | First word address of the burst |
| mem_len | output | BL | Words in the burst |
| mem_ack | input | 1 | Request accepted |
| mem_valid | input | 1 | Read data beat valid |
| mem_data | input | 32 | Read data word |
| lcd_d | output | 4 | Four pixels to the panel |
| lcd_shift | output | 1 | Shift strobe, one per group of four pixels |
| lcd_line | output | 1 | Line pulse after the last pixel of a line |
| lcd_frame | output | 1 | High during the first line of a frame |
| underflow | output | 1 | Sticky FIFO starvation flag |

## Verification
The bench builds the block with its default parameters: an 8-word FIFO, 4-word bursts, 15-bit word addresses and 8-bit line counts. Those sizes reach the shortest 16-pixel line (half a word at 1 bpp), the full 1024-pixel line (128 words at 4 bpp) and bursts cut short at frame wrap. Runs of more than 16 frames cycle the grey pattern counter through its full range. A stalled memory drains the FIFO and exercises the blank-and-resynchronise path, and the re-enable that follows shows that late words from the old setting are dropped.

// File: rtl/lcd_mono_ctrl.sv
module lcd_mono_ctrl #(
  parameter int AW    = 15,
  parameter int LW    = 8,
  parameter int DEPTH = 8,
  parameter int BURST = 4,
  parameter int BL    = $clog2(BURST + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [5:0]    cfg_len,
  input  logic [1:0]    cfg_bpp,
  input  logic [LW-1:0] cfg_lines,
  input  logic [AW-1:0] cfg_base,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [BL-1:0] mem_len,
  input  logic          mem_ack,
  input  logic          mem_valid,
  input  logic [31:0]   mem_data,
  output logic [3:0]    lcd_d,
  output logic          lcd_shift,
  output logic          lcd_line,
  output logic          lcd_frame,
  output logic          underflow
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int OW = CW + 1;
  localparam int FW = LW + 9;

  logic [5:0]    len_q;
  logic [1:0]    bpp_q;
  logic [LW-1:0] lines_q;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      len_q <= '0; bpp_q <= '0; lines_q <= '0; base_q <= '0;
    end else if (!en) begin
      len_q <= cfg_len; bpp_q <= cfg_bpp; lines_q <= cfg_lines; base_q <= cfg_base;
    end

  logic [8:0] wpl;
  always_comb
    case (bpp_q)
      2'd0:    wpl = (9'(len_q) + 9'd2) >> 1;
      2'd1:    wpl = 9'(len_q) + 9'd1;
      default: wpl = (9'(len_q) + 9'd1) << 1;
    endcase

  logic [2:0]    gpw_m1;
  logic [FW-1:0] fwords, foff, rem;
  logic [BL-1:0] blen;
  assign gpw_m1 = (bpp_q == 2'd0) ? 3'd7 : (bpp_q == 2'd1) ? 3'd3 : 3'd1;
  assign fwords = FW'(wpl) * (FW'(lines_q) + FW'(1));
  assign rem    = fwords - foff;
  assign blen   = (rem < FW'(BURST)) ? BL'(rem) : BL'(BURST);

  logic [31:0]   fifo [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt, pending, pend_n;
  logic [OW-1:0] occ;
  logic [15:0]   debt;
  logic          issue, push, pop, empty, room;

  assign occ    = {1'b0, cnt} + {1'b0, pending};
  assign room   = occ <= OW'(DEPTH - BURST);
  assign issue  = en && !mem_req && room;
  assign pend_n = pending + (issue ? CW'(blen) : '0) - CW'(mem_valid);
  assign push   = en && mem_valid && (debt == 16'd0);
  assign empty  = (cnt == '0);

  logic          run, lp_ph;
  logic [7:0]    grp;
  logic [2:0]    wsub;
  logic [LW-1:0] line_q;
  logic [3:0]    frm;
  logic [31:0]   cw, word;
  logic          shifting, need, uf_now;
  logic [3:0]    pix;

  assign shifting = run && !lp_ph;
  assign need     = shifting && (wsub == 3'd0);
  assign pop      = need && !empty;
  assign uf_now   = need && empty;
  assign word     = (wsub != 3'd0) ? cw : (empty ? 32'd0 : fifo[rp]);

  always_comb
    for (int j = 0; j < 4; j++) begin
      logic [4:0] idx;
      case (bpp_q)
        2'd0: begin
          idx    = 5'({wsub, 2'b00}) + 5'(j);
          pix[j] = word[idx];
        end
        2'd1: begin
          idx    = 5'({wsub, 3'b000}) + 5'(2 * j);
          pix[j] = word[idx +: 2] > frm[1:0];
        end
        default: begin
          idx    = 5'({wsub, 4'b0000}) + 5'(4 * j);
          pix[j] = word[idx +: 4] > frm;
        end
      endcase
    end

  assign lcd_shift = shifting;
  assign lcd_line  = run && lp_ph;
  assign lcd_frame = run && (line_q == '0);
  assign lcd_d     = shifting ? pix : 4'd0;

  always_ff @(posedge clk)
    if (push) fifo[wp] <= mem_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mem_req <= 1'b0; mem_addr <= '0; mem_len <= '0; foff <= '0;
      pending <= '0; debt <= '0; cnt <= '0; wp <= '0; rp <= '0;
      run <= 1'b0; lp_ph <= 1'b0; grp <= '0; wsub <= '0; line_q <= '0;
      frm <= '0; cw <= '0; underflow <= 1'b0;
    end else begin
      pending <= pend_n;
      if (!en) begin
        debt    <= 16'(pend_n);
        mem_req <= mem_req && !mem_ack;
        foff <= '0; cnt <= '0; wp <= '0; rp <= '0;
        run <= 1'b0; lp_ph <= 1'b0; grp <= '0; wsub <= '0; line_q <= '0;
        frm <= '0; underflow <= 1'b0;
      end else begin
        debt <= debt - 16'(mem_valid && debt != 16'd0) + 16'(uf_now);
        if (mem_req && mem_ack) mem_req <= 1'b0;
        else if (issue) begin
          mem_req  <= 1'b1;
          mem_addr <= base_q + AW'(foff);
          mem_len  <= blen;
          foff     <= (foff + FW'(blen) == fwords) ? '0 : foff + FW'(blen);
        end
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
        if (uf_now) underflow <= 1'b1;
        if (need) cw <= word;
        if (!run && cnt >= CW'(BURST)) run <= 1'b1;
        if (shifting) begin
          if (grp == {len_q, 2'b11}) begin
            grp <= '0; wsub <= '0; lp_ph <= 1'b1;
          end else begin
            grp  <= grp + 8'd1;
            wsub <= (wsub == gpw_m1) ? 3'd0 : wsub + 3'd1;
          end
        end else if (lp_ph) begin
          lp_ph <= 1'b0;
          if (line_q == lines_q) begin
            line_q <= '0;
            frm    <= frm + 4'd1;
          end else line_q <= line_q + 1'b1;
        end
      end
    end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(DEPTH) || pop));
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_len));
  a_r2_line_then_shift: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_line && en |=> lcd_shift || !en);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en && underflow |=> underflow || !en);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !lcd_shift && !lcd_line && !underflow);
endmodule

// File: tb/lcd_mono_ctrl_tb_top.sv
module lcd_mono_ctrl_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, en = 1'b0;
  logic [5:0]  cfg_len = '0;
  logic [1:0]  cfg_bpp = '0;
  logic [7:0]  cfg_lines = '0;
  logic [14:0] cfg_base = '0;
  logic        mem_req, mem_ack = 1'b0, mem_valid = 1'b0;
  logic [14:0] mem_addr;
  logic [2:0]  mem_len;
  logic [31:0] mem_data = '0;
  logic [3:0]  lcd_d;
  logic        lcd_shift, lcd_line, lcd_frame, underflow;

  lcd_mono_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_len(cfg_len), .cfg_bpp(cfg_bpp),
    .cfg_lines(cfg_lines), .cfg_base(cfg_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_ack(mem_ack), .mem_valid(mem_valid), .mem_data(mem_data),
    .lcd_d(lcd_d), .lcd_shift(lcd_shift), .lcd_line(lcd_line), .lcd_frame(lcd_frame),
    .underflow(underflow));

  int errors = 0, checks = 0, cyc = 0;
  int q_addr[$], q_rdy[$];
  bit stall = 0, cmp_on = 0, fetch_chk = 0, mst = 0;
  string ftag = "R7";
  int m_len, m_bpp, m_lines, m_base, m_wpl, m_gpw, m_fw;
  int m_line, m_grp, m_frm, e_off, req_total, consumed, delivered;
  bit m_lp;

  function automatic logic [31:0] memf(int a);
    return (a * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
  endfunction

  function automatic int exp_pix(logic [31:0] w, int sub, int bpp, int frm);
    int r = 0;
    for (int j = 0; j < 4; j++) begin
      int b;
      if (bpp == 0)      b = int'(w[sub * 4 + j]);
      else if (bpp == 1) b = (int'((w >> (sub * 8 + 2 * j)) & 32'd3) > (frm % 4)) ? 1 : 0;
      else               b = (int'((w >> (sub * 16 + 4 * j)) & 32'd15) > frm) ? 1 : 0;
      r |= b << j;
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk); #1; cyc++;
    if (cyc > 150000) begin
      chk(0, "R11 watchdog", cyc, 150000);
      finish_run();
    end
    if (cmp_on) begin
      if (!mst && lcd_shift) begin
        mst = 1;
        chk(delivered >= 4, "R11", delivered, 4);
      end
      if (mst) begin
        chk(lcd_shift == !m_lp && lcd_line == m_lp, "R2",
            {lcd_shift, lcd_line}, {!m_lp, m_lp});
        chk(lcd_frame == (m_line == 0), "R6", lcd_frame, m_line == 0);
        if (!m_lp) begin
          int e = exp_pix(memf(m_base + m_line * m_wpl + m_grp / m_gpw), m_grp % m_gpw, m_bpp, m_frm);
          chk(int'(lcd_d) == e, m_bpp == 0 ? "R3/R4" : "R3/R5", lcd_d, e);
          if (m_grp % m_gpw == 0) consumed++;
        end
        if (m_lp) begin
          m_lp = 0;
          if (m_line == m_lines) begin m_line = 0; m_frm = (m_frm + 1) % 16; end
          else m_line++;
        end else if (m_grp == 4 * (m_len + 1) - 1) begin
          m_grp = 0; m_lp = 1;
        end else m_grp++;
      end
    end
    mem_valid = 0;
    if (q_addr.size() > 0 && q_rdy[0] <= cyc) begin
      mem_valid = 1;
      mem_data = memf(q_addr.pop_front());
      void'(q_rdy.pop_front());
      delivered++;
    end
    mem_ack = 0;
    if (mem_req && !stall) begin
      mem_ack = 1;
      if (fetch_chk) begin
        int el = (m_fw - e_off < 4) ? m_fw - e_off : 4;
        chk(int'(mem_addr) == m_base + e_off && int'(mem_len) == el, ftag,
            int'(mem_addr) * 8 + int'(mem_len), (m_base + e_off) * 8 + el);
        e_off += int'(mem_len);
        if (e_off >= m_fw) e_off = 0;
        req_total += int'(mem_len);
        chk(req_total - consumed <= 8, "R8", req_total - consumed, 8);
      end
      for (int i = 0; i < int'(mem_len); i++) begin
        q_addr.push_back(int'(mem_addr) + i);
        q_rdy.push_back(cyc + 2 + i);
      end
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk_idle(string tag);
    chk(!lcd_shift && !lcd_line && !lcd_frame && !underflow, tag,
        {lcd_shift, lcd_line, lcd_frame, underflow}, 0);
  endtask

  task automatic run_cfg(int len, int bpp, int lines_m1, int base, int n, string tg);
    cfg_len = 6'(len); cfg_bpp = 2'(bpp); cfg_lines = 8'(lines_m1); cfg_base = 15'(base);
    ticks(2);
    m_len = len; m_bpp = bpp; m_lines = lines_m1; m_base = base;
    m_wpl = (bpp == 0) ? (len + 2) / 2 : (bpp == 1) ? len + 1 : 2 * (len + 1);
    m_gpw = (bpp == 0) ? 8 : (bpp == 1) ? 4 : 2;
    m_fw = m_wpl * (lines_m1 + 1);
    m_line = 0; m_grp = 0; m_frm = 0; m_lp = 0; mst = 0;
    e_off = 0; req_total = 0; consumed = 0; delivered = 0; ftag = tg;
    en = 1; cmp_on = 1; fetch_chk = 1;
    for (int k = 0; k < 100 && !mst; k++) tick();
    chk(mst, "R11", mst, 1);
    ticks(n);
    chk(!underflow, "R9", underflow, 0);
    cmp_on = 0; fetch_chk = 0; en = 0;
    tick();
    chk_idle("R1");
    ticks(12);
  endtask

  initial begin
    ticks(3);
    chk_idle("R1");
    chk(!mem_req, "R1", mem_req, 0);
    rst_n = 1;
    ticks(3);
    chk_idle("R1");
    chk(!mem_req, "R1", mem_req, 0);

    run_cfg(0, 0, 2, 'h100, 60, "R7");
    run_cfg(1, 1, 1, 'h40, 400, "R7");
    run_cfg(3, 2, 2, 'h200, 900, "R7");
    run_cfg(63, 2, 1, 'h1000, 1100, "R7");
    run_cfg(4, 0, 4, 'h7, 300, "R7");

    cfg_len = 6'd3; cfg_bpp = 2'd2; cfg_lines = 8'd1; cfg_base = 15'h300;
    ticks(2);
    en = 1;
    ticks(60);
    chk(!underflow, "R9", underflow, 0);
    stall = 1;
    ticks(60);
    chk(underflow, "R9", underflow, 1);
    begin
      int lp = 0;
      for (int i = 0; i < 34; i++) begin
        tick();
        if (lcd_line) lp++;
        if (lcd_shift) chk(lcd_d == 4'd0, "R9", lcd_d, 0);
      end
      chk(lp == 2, "R9", lp, 2);
    end
    stall = 0;
    en = 0;
    tick();
    chk_idle("R9");
    ticks(20);

    run_cfg(2, 1, 3, 'h500, 300, "R10");
    chk(q_addr.size() == 0, "R10", q_addr.size(), 0);
    finish_run();
  end
endmodule